// File: doc/BRIEF.md
# Black-Level Servo

This block holds the digitised black level of an image sensor at a chosen code. Each line of the sensor carries a run of light-shielded pixels, and a strobe marks that run. While the strobe is high, the block sums the difference between every incoming converter sample and a programmable target. When the strobe falls, it turns that sum into a correction step and adds the step into a signed offset word. The word feeds an offset converter ahead of the sampling chain, so the loop keeps pulling the shielded pixels back to the target.

The step is the mean error, found with a right shift by the floor of log2 of the pixel count, then scaled down again by a programmable shift that sets the loop bandwidth. Updates can be spread over several lines, in which case the sum runs across every window in the interval. When the loop is switched off, because the black level is being restored digitally further down the pipeline, the target value is passed straight through as a fixed offset.

Top module: `black_servo`

## Requirements
- R1: Samples are added to the error sum only on cycles where `ob_window` is high; samples on other cycles have no effect on the output.
- R2: The error of one sample is `adc_code` minus `clamp_level`, with both read as unsigned numbers; the target range is 0 to 255.
- R3: At a commit with a pixel count c > 0, the step is the signed sum shifted arithmetically right by floor(log2(c)) + `filter_shift`, and `offset_corr` becomes the old value minus that step, so a sample above target drives the word down.
- R4: A commit happens only at the first clock edge where `ob_window` is sampled low after being sampled high, and `offset_corr` takes the new value at that edge. It holds at all other times while the loop is on.
- R5: `line_interval` = N makes a commit on every Nth window end, with the sum and count running across all N windows; N = 0 behaves as N = 1.
- R6: `offset_corr` saturates at -2^(CORR_W-1) and 2^(CORR_W-1)-1 (-512 and 511 by default) and never wraps.
- R7: While `loop_enable` is low, `offset_corr` equals `clamp_level` zero-extended from the edge after it is sampled, and the sum, the count and the line tally are cleared, so a re-enabled loop starts from that value with no leftover error.
- R8: After reset, `offset_corr` is 0 and the sum, the count and the line tally are clear.
- R9: The pixel count in one interval stops at 2^CNT_W - 1 (4095 by default); later samples in that interval are dropped from both the sum and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_code | input | SAMPLE_W | Unsigned converter sample |
| ob_window | input | 1 | High on shielded black pixels |
| clamp_level | input | LEVEL_W | Black target, or fixed offset when the loop is off |
| loop_enable | input | 1 | 1 runs the servo, 0 passes the level through |
| line_interval | input | RATE_W | Lines per update (0 is treated as 1) |
| filter_shift | input | SHIFT_W | Extra right shift of the mean error |
| offset_corr | output | CORR_W | Signed offset correction word |

## Verification
The assertions check on every cycle that commits fall only on window ends, that the word holds between commits, that the pixel count is frozen outside the window, that a step moves the word against the sign of the error, and that a disabled loop shows the level. The exact values of the arithmetic can only be shown by the bench's scenarios: rounding of non-power-of-two windows, the bandwidth shift, averaging across several lines, clipping at both rails, the count limit, and a clean restart after the loop is switched off.

// File: rtl/black_servo_pkg.sv
package black_servo_pkg;

  // index of the highest set bit; 0 for an input of 0 or 1
  function automatic int msb_index(input longint unsigned v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n = i;
    end
    return n;
  endfunction

  // mean error scaled by the bandwidth shift
  function automatic longint servo_step(input longint sum, input longint unsigned count,
                                        input int bw_shift);
    return sum >>> (msb_index(count) + bw_shift);
  endfunction

  // clip a value into a signed range of the given width
  function automatic longint clip_signed(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/bs_win_edge.sv
module bs_win_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  output logic win_fall
);
  logic win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win;
  end

  assign win_fall = win_q & ~win;
endmodule

// File: rtl/bs_err_accum.sv
module bs_err_accum #(
  parameter int SAMPLE_W = 10,
  parameter int LEVEL_W  = 8,
  parameter int CNT_W    = 12,
  localparam int ERR_W   = SAMPLE_W + 2,
  localparam int ACC_W   = ERR_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    win,
  input  logic [SAMPLE_W-1:0]     sample,
  input  logic [LEVEL_W-1:0]      level,
  output logic signed [ACC_W-1:0] err_sum,
  output logic [CNT_W-1:0]        pix_cnt
);
  logic signed [ERR_W-1:0] err;
  logic                    cnt_full;

  assign err      = $signed({2'b00, sample}) - $signed({{(ERR_W - LEVEL_W){1'b0}}, level});
  assign cnt_full = &pix_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err_sum <= '0;
      pix_cnt <= '0;
    end else if (win && !cnt_full) begin
      err_sum <= err_sum + {{CNT_W{err[ERR_W-1]}}, err};
      pix_cnt <= pix_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bs_line_pacer.sv
module bs_line_pacer #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              win_fall,
  input  logic [RATE_W-1:0] rate,
  output logic              commit
);
  logic [RATE_W-1:0] lines;
  logic [RATE_W:0]   lines_next;
  logic [RATE_W:0]   eff_rate;

  assign lines_next = {1'b0, lines} + 1'b1;
  assign eff_rate   = (rate == '0) ? (RATE_W+1)'(1) : {1'b0, rate};
  assign commit     = en & win_fall & (lines_next >= eff_rate);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || commit) lines <= '0;
    else if (win_fall)           lines <= lines + 1'b1;
  end
endmodule

// File: rtl/bs_corr_integ.sv
module bs_corr_integ
  import black_servo_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int CORR_W  = 10,
  parameter int ACC_W   = 24,
  parameter int CNT_W   = 12,
  parameter int SHIFT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     commit,
  input  logic signed [ACC_W-1:0]  err_sum,
  input  logic [CNT_W-1:0]         pix_cnt,
  input  logic [SHIFT_W-1:0]       bw_shift,
  input  logic [LEVEL_W-1:0]       level,
  output logic signed [ACC_W-1:0]  avg_step,
  output logic signed [CORR_W-1:0] corr
);
  assign avg_step = ACC_W'(servo_step(longint'(err_sum), 64'(pix_cnt), int'(bw_shift)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr <= '0;
    end else if (!en) begin
      corr <= $signed({{(CORR_W - LEVEL_W){1'b0}}, level});
    end else if (commit && pix_cnt != '0) begin
      corr <= CORR_W'(clip_signed(longint'(corr) - longint'(avg_step), CORR_W));
    end
  end
endmodule

// File: rtl/black_servo.sv
module black_servo #(
  parameter int SAMPLE_W = 10,
  parameter int LEVEL_W  = 8,
  parameter int CORR_W   = 10,
  parameter int CNT_W    = 12,
  parameter int RATE_W   = 4,
  parameter int SHIFT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SAMPLE_W-1:0]      adc_code,
  input  logic                     ob_window,
  input  logic [LEVEL_W-1:0]       clamp_level,
  input  logic                     loop_enable,
  input  logic [RATE_W-1:0]        line_interval,
  input  logic [SHIFT_W-1:0]       filter_shift,
  output logic signed [CORR_W-1:0] offset_corr
);
  localparam int ACC_W = SAMPLE_W + 2 + CNT_W;

  logic                    win_fall;
  logic                    commit;
  logic                    sum_clear;
  logic signed [ACC_W-1:0] err_sum;
  logic [CNT_W-1:0]        pix_cnt;
  logic signed [ACC_W-1:0] avg_step;

  assign sum_clear = commit | ~loop_enable;

  bs_win_edge u_edge (
    .clk(clk), .rst_n(rst_n), .win(ob_window), .win_fall(win_fall)
  );

  bs_err_accum #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(sum_clear), .win(ob_window),
    .sample(adc_code), .level(clamp_level), .err_sum(err_sum), .pix_cnt(pix_cnt)
  );

  bs_line_pacer #(.RATE_W(RATE_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(loop_enable), .win_fall(win_fall),
    .rate(line_interval), .commit(commit)
  );

  bs_corr_integ #(.LEVEL_W(LEVEL_W), .CORR_W(CORR_W), .ACC_W(ACC_W),
                  .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(loop_enable), .commit(commit),
    .err_sum(err_sum), .pix_cnt(pix_cnt), .bw_shift(filter_shift),
    .level(clamp_level), .avg_step(avg_step), .corr(offset_corr)
  );
endmodule

// File: rtl/black_servo_chk.sv
module black_servo_chk #(
  parameter int LEVEL_W = 8,
  parameter int CORR_W  = 10,
  parameter int ACC_W   = 24,
  parameter int CNT_W   = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ob_window,
  input logic                     loop_enable,
  input logic [LEVEL_W-1:0]       clamp_level,
  input logic                     win_fall,
  input logic                     commit,
  input logic [CNT_W-1:0]         pix_cnt,
  input logic signed [ACC_W-1:0]  avg_step,
  input logic signed [CORR_W-1:0] offset_corr
);
  // R4: commits only ever come from a window end
  p_commit_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> win_fall);

  // R4: word holds unless the previous edge committed or the loop was off
  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(loop_enable) && !$past(commit)) |-> $stable(offset_corr));

  // R1: nothing is counted outside the window
  p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_enable && !ob_window && !commit) |=> $stable(pix_cnt));

  // R3: a positive mean error never raises the word, a negative one never lowers it
  p_down_on_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pix_cnt != '0 && avg_step > 0) |=> (offset_corr <= $past(offset_corr)));
  p_up_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pix_cnt != '0 && avg_step < 0) |=> (offset_corr >= $past(offset_corr)));

  // R7: a disabled loop passes the level through
  p_static_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(loop_enable)) |->
      (offset_corr == $signed({{(CORR_W - LEVEL_W){1'b0}}, $past(clamp_level)})));
endmodule

bind black_servo black_servo_chk #(
  .LEVEL_W(LEVEL_W), .CORR_W(CORR_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ob_window(ob_window), .loop_enable(loop_enable),
  .clamp_level(clamp_level), .win_fall(win_fall), .commit(commit),
  .pix_cnt(pix_cnt), .avg_step(avg_step), .offset_corr(offset_corr)
);

// File: tb/black_servo_bench.sv
module black_servo_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [9:0]        adc_code = '0;
  logic              ob_window = 1'b0;
  logic [7:0]        clamp_level = '0;
  logic              loop_enable = 1'b0;
  logic [3:0]        line_interval = 4'd1;
  logic [2:0]        filter_shift = '0;
  logic signed [9:0] offset_corr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  longint m_acc;
  int     m_cnt, m_lines, m_corr;
  bit     m_winq;

  always #10 clk = ~clk;

  black_servo u_black_servo (
    .clk(clk), .rst_n(rst_n), .adc_code(adc_code), .ob_window(ob_window),
    .clamp_level(clamp_level), .loop_enable(loop_enable),
    .line_interval(line_interval), .filter_shift(filter_shift),
    .offset_corr(offset_corr)
  );

  function automatic int top_bit(input int v);
    int n = 0;
    int t = v;
    while (t > 1) begin t = t / 2; n++; end
    return n;
  endfunction

  function automatic int rail(input longint v);
    if (v > 511)  return 511;
    if (v < -512) return -512;
    return int'(v);
  endfunction

  // reference model of the requirements, advanced once per clock edge
  task automatic model_step();
    bit fall;
    int eff;
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_lines = 0; m_corr = 0; m_winq = 0;
      return;
    end
    fall = m_winq && !ob_window;
    if (!loop_enable) begin
      m_corr = int'(clamp_level); m_acc = 0; m_cnt = 0; m_lines = 0;
    end else begin
      if (ob_window && m_cnt < 4095) begin
        m_acc = m_acc + longint'(adc_code) - longint'(clamp_level);
        m_cnt++;
      end
      if (fall) begin
        eff = (line_interval == 0) ? 1 : int'(line_interval);
        if (m_lines + 1 >= eff) begin
          if (m_cnt != 0)
            m_corr = rail(longint'(m_corr) - (m_acc >>> (top_bit(m_cnt) + int'(filter_shift))));
          m_acc = 0; m_cnt = 0; m_lines = 0;
        end else m_lines++;
      end
    end
    m_winq = ob_window;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_line(input int n_win, input int s_in, input int s_out);
    for (int i = 0; i < 3; i++) begin ob_window = 0; adc_code = 10'(s_out); tick(); end
    for (int i = 0; i < n_win; i++) begin ob_window = 1; adc_code = 10'(s_in); tick(); end
    for (int i = 0; i < 4; i++) begin ob_window = 0; adc_code = 10'(s_out); tick(); end
  endtask

  function automatic int corr_now();
    return int'(offset_corr);
  endfunction

  task automatic t_reset();
    rst_n = 0; loop_enable = 1; tick(); tick(); tick();
    chk("R8 reset value", corr_now(), 0);
    rst_n = 1; tick();
    chk("R8 after release", corr_now(), 0);
  endtask

  task automatic t_basic();
    clamp_level = 64; line_interval = 1; filter_shift = 0;
    drive_line(16, 80, 0);
    chk("R2 R3 above target", corr_now(), -16);
    drive_line(16, 40, 0);
    chk("R3 below target", corr_now(), 8);
  endtask

  task automatic t_outside();
    drive_line(16, 64, 1023);
    chk("R1 outside samples ignored", corr_now(), 8);
    chk("R1 model agrees", corr_now(), m_corr);
  endtask

  task automatic t_hold();
    ob_window = 0; adc_code = 0; tick(); tick();
    for (int i = 0; i < 10; i++) begin ob_window = 1; adc_code = 100; tick(); end
    chk("R4 holds inside window", corr_now(), 8);
    ob_window = 0; adc_code = 0; tick();
    chk("R4 update at window end", corr_now(), -37);
    tick(); tick();
    chk("R4 holds after update", corr_now(), -37);
  endtask

  task automatic t_short_and_shift();
    drive_line(5, 72, 0);
    chk("R3 five-pixel window", corr_now(), -47);
    filter_shift = 2;
    drive_line(16, 96, 0);
    chk("R3 bandwidth shift", corr_now(), -55);
    filter_shift = 0;
  endtask

  task automatic t_rate();
    line_interval = 3;
    drive_line(8, 80, 0);
    chk("R5 no update line 1", corr_now(), -55);
    drive_line(8, 80, 0);
    chk("R5 no update line 2", corr_now(), -55);
    drive_line(8, 48, 0);
    chk("R5 update on line 3", corr_now(), -63);
    line_interval = 0;
    drive_line(8, 72, 0);
    chk("R5 zero interval as one", corr_now(), -71);
    line_interval = 1;
  endtask

  task automatic t_saturate();
    int exp_seq[5] = '{-257, -2, 253, 508, 511};
    clamp_level = 0;
    drive_line(16, 1023, 0);
    chk("R6 low rail", corr_now(), -512);
    clamp_level = 255;
    for (int i = 0; i < 5; i++) begin
      drive_line(16, 0, 0);
      chk("R6 climb", corr_now(), exp_seq[i]);
    end
    drive_line(16, 0, 0);
    chk("R6 high rail no wrap", corr_now(), 511);
  endtask

  task automatic t_count_cap();
    clamp_level = 60;
    drive_line(4100, 64, 0);
    chk("R9 count limit", corr_now(), 504);
    chk("R9 model agrees", corr_now(), m_corr);
  endtask

  task automatic t_disable();
    loop_enable = 0; clamp_level = 100; tick();
    chk("R7 level passes through", corr_now(), 100);
    clamp_level = 37; tick();
    chk("R7 follows new level", corr_now(), 37);
    drive_line(16, 1023, 0);
    chk("R7 window ignored when off", corr_now(), 37);
    loop_enable = 1;
    drive_line(16, 37, 0);
    chk("R7 restart from level", corr_now(), 37);
    drive_line(16, 53, 0);
    chk("R7 clean sum after restart", corr_now(), 21);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_outside();
    t_hold();
    t_short_and_shift();
    t_rate();
    t_saturate();
    t_count_cap();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule